// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block carries 18-bit words from one clock domain to another. A producer writes at its own clock with a write enable. A consumer reads at an unrelated clock and gets a registered data word. The storage depth is a parameter, 256 or 512 words. Pointers cross between the domains in Gray code through two-flop synchronisers.

Four active-low status flags report the fill level. Full and almost-full belong to the write domain. Empty and almost-empty belong to the read domain. The two almost thresholds come from 9-bit offset inputs. Each domain samples its offset into a register that resets to 8. When the depth is 256, bit 8 of each offset is ignored.

Because pointers cross domains, a flag is released a fixed number of the observing clock's edges after the event that frees it. A flag is never released early. Reads while empty and writes while full are dropped.

Top module: `dcf_fifo`

## Requirements
- R1: While rst_ni is low, empty_n_o and aempty_n_o are 0, full_n_o and afull_n_o are 1, and rd_data_o is 0. Both offsets return to 8.
- R2: Words leave in the order they were written. rd_data_o loads the next word on the read-clock edge of an accepted read, which is rd_en_i high while empty_n_o is high. Otherwise rd_data_o holds its value.
- R3: Once settled, empty_n_o is 0 exactly when the FIFO holds no words. A read requested while empty_n_o is 0 is ignored, and rd_data_o does not change.
- R4: Once settled, full_n_o is 0 exactly when the FIFO holds DEPTH words. A write requested while full_n_o is 0 is ignored, and the word is never read out.
- R5: Once settled, aempty_n_o is 0 when the word count is at or below the almost-empty offset n, and 1 when the count is above n.
- R6: Once settled, afull_n_o is 0 when the word count is at or above DEPTH minus the almost-full offset m, and 1 when the count is below it.
- R7: Each offset input is sampled on every clock of its own domain. A changed offset governs its flag from the second edge after the change.
- R8: After a write into an empty FIFO, empty_n_o rises on the third read-clock rising edge after the write edge. After a read from a full FIFO, full_n_o rises on the third write-clock rising edge after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| wclk_i | input | 1 | Write clock |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 18 | Write data |
| afull_ofs_i | input | 9 | Almost-full offset m |
| full_n_o | output | 1 | Full flag, active low, write domain |
| afull_n_o | output | 1 | Almost-full flag, active low, write domain |
| rclk_i | input | 1 | Read clock |
| rd_en_i | input | 1 | Read request |
| aempty_ofs_i | input | 9 | Almost-empty offset n |
| rd_data_o | output | 18 | Registered read data |
| empty_n_o | output | 1 | Empty flag, active low, read domain |
| aempty_n_o | output | 1 | Almost-empty flag, active low, read domain |

## Verification
Flags in a port's own domain respond on the same edge as that port's access. Read data is due on the read-clock edge of an accepted read, and the bench samples it a fraction of a nanosecond after that edge. Flags driven by the far domain take three of the observing clock's edges. The bench checks those two release latencies by counting edges exactly. Every other flag check waits six edges of each clock with no traffic, so it compares settled values against the word count of the bench's own queue model.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int unsigned OFS_W   = 9;
  localparam int unsigned DEF_OFS = 8;

  function automatic logic [15:0] gray2bin(logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
`timescale 1ns/1ps
module dcf_mem #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register moves only on an accepted read
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [PW-1:0]    far_gray_i,
  output logic             push_o,
  output logic [PW-1:0]    bin_o,
  output logic [PW-1:0]    gray_o,
  output logic             full_n_o,
  output logic             afull_n_o
);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(DEPTH - 1);

  logic [OFS_W-1:0] ofs_q;
  logic [PW-1:0]    bin_d, far_bin, used_d, limit;

  assign push_o  = req_i & full_n_o;
  assign bin_d   = bin_o + PW'(push_o);
  assign far_bin = PW'(gray2bin(16'(far_gray_i)));
  assign used_d  = bin_d - far_bin;
  assign limit   = PW'(DEPTH) - PW'(ofs_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o     <= '0;
      gray_o    <= '0;
      ofs_q     <= OFS_W'(DEF_OFS);
      full_n_o  <= 1'b1;
      afull_n_o <= 1'b1;
    end else begin
      bin_o     <= bin_d;
      gray_o    <= bin_d ^ (bin_d >> 1);
      ofs_q     <= ofs_i & OFS_MASK;
      full_n_o  <= (used_d != PW'(DEPTH));
      afull_n_o <= (used_d < limit);
    end
  end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [PW-1:0]    far_gray_i,
  output logic             pop_o,
  output logic [PW-1:0]    bin_o,
  output logic [PW-1:0]    gray_o,
  output logic             empty_n_o,
  output logic             aempty_n_o
);
  localparam logic [OFS_W-1:0] OFS_MASK = OFS_W'(DEPTH - 1);

  logic [OFS_W-1:0] ofs_q;
  logic [PW-1:0]    bin_d, far_bin, used_d;

  assign pop_o   = req_i & empty_n_o;
  assign bin_d   = bin_o + PW'(pop_o);
  assign far_bin = PW'(gray2bin(16'(far_gray_i)));
  assign used_d  = far_bin - bin_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_o      <= '0;
      gray_o     <= '0;
      ofs_q      <= OFS_W'(DEF_OFS);
      empty_n_o  <= 1'b0;
      aempty_n_o <= 1'b0;
    end else begin
      bin_o      <= bin_d;
      gray_o     <= bin_d ^ (bin_d >> 1);
      ofs_q      <= ofs_i & OFS_MASK;
      empty_n_o  <= (used_d != '0);
      aempty_n_o <= (used_d > PW'(ofs_q));
    end
  end
endmodule

// File: rtl/dcf_fifo.sv
`timescale 1ns/1ps
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             rst_ni,
  input  logic             wclk_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [OFS_W-1:0] afull_ofs_i,
  output logic             full_n_o,
  output logic             afull_n_o,
  input  logic             rclk_i,
  input  logic             rd_en_i,
  input  logic [OFS_W-1:0] aempty_ofs_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             empty_n_o,
  output logic             aempty_n_o
);
  logic          push, pop;
  logic [PW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0] wr_gray_rs, rd_gray_ws;

  dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .req_i(wr_en_i), .ofs_i(afull_ofs_i),
    .far_gray_i(rd_gray_ws), .push_o(push), .bin_o(wr_bin), .gray_o(wr_gray),
    .full_n_o(full_n_o), .afull_n_o(afull_n_o)
  );

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .req_i(rd_en_i), .ofs_i(aempty_ofs_i),
    .far_gray_i(wr_gray_rs), .pop_o(pop), .bin_o(rd_bin), .gray_o(rd_gray),
    .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_gray), .q_o(wr_gray_rs)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_gray), .q_o(rd_gray_ws)
  );

  dcf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk_i(wclk_i), .we_i(push), .waddr_i(wr_bin[AW-1:0]), .wdata_i(wr_data_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(pop), .raddr_i(rd_bin[AW-1:0]),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
`timescale 1ns/1ps
module dcf_fifo_chk #(
  parameter int unsigned DW = 18,
  parameter int unsigned PW = 10
) (
  input logic          rst_ni,
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          full_n_o,
  input logic          afull_n_o,
  input logic          empty_n_o,
  input logic          aempty_n_o,
  input logic [DW-1:0] rd_data_o,
  input logic [PW-1:0] wr_bin,
  input logic [PW-1:0] rd_bin,
  input logic [PW-1:0] wr_gray
);
  AST_WR_DROPPED_FULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_en_i && !full_n_o) |=> $stable(wr_bin)); // R4

  AST_RD_DROPPED_EMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_n_o) |=> $stable(rd_bin)); // R3

  AST_RDATA_HOLD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(rd_en_i && empty_n_o) |=> $stable(rd_data_o)); // R2

  AST_FULL_IN_AFULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_n_o |-> !afull_n_o); // R6

  AST_EMPTY_IN_AEMPTY: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_n_o |-> !aempty_n_o); // R5

  AST_GRAY_ONE_STEP: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $onehot0(wr_gray ^ $past(wr_gray))); // R8
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .rst_ni(rst_ni), .wclk_i(wclk_i), .rclk_i(rclk_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .full_n_o(full_n_o), .afull_n_o(afull_n_o),
  .empty_n_o(empty_n_o), .aempty_n_o(aempty_n_o), .rd_data_o(rd_data_o),
  .wr_bin(wr_bin), .rd_bin(rd_bin), .wr_gray(wr_gray)
);

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;
  localparam int DW = 18;
  localparam int DEPTH = 512;

  logic rst_n = 1'b0;
  logic wclk = 1'b0, rclk = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [8:0] afull_ofs = 9'd8, aempty_ofs = 9'd8;
  logic full_n, afull_n, empty_n, aempty_n;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;
  int n_cur = 8, m_cur = 8;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd = '0;

  always #2.5 wclk = ~wclk;
  initial begin
    #1.1;
    forever begin rclk = ~rclk; #3.5; end
  end

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
    .rst_ni(rst_n), .wclk_i(wclk), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .afull_ofs_i(afull_ofs), .full_n_o(full_n), .afull_n_o(afull_n),
    .rclk_i(rclk), .rd_en_i(rd_en), .aempty_ofs_i(aempty_ofs),
    .rd_data_o(rd_data), .empty_n_o(empty_n), .aempty_n_o(aempty_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_empty_n(int c);  return c != 0;             endfunction
  function automatic bit exp_aempty_n(int c); return c > n_cur;          endfunction
  function automatic bit exp_full_n(int c);   return c != DEPTH;         endfunction
  function automatic bit exp_afull_n(int c);  return c < DEPTH - m_cur;  endfunction

  task automatic settle_check();
    int c;
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #0.2;
    c = q.size();
    chk(empty_n == exp_empty_n(c), "R3 empty", int'(empty_n), int'(exp_empty_n(c)));
    chk(full_n == exp_full_n(c), "R4 full", int'(full_n), int'(exp_full_n(c)));
    chk(aempty_n == exp_aempty_n(c), "R5 aempty", int'(aempty_n), int'(exp_aempty_n(c)));
    chk(afull_n == exp_afull_n(c), "R6 afull", int'(afull_n), int'(exp_afull_n(c)));
  endtask

  task automatic wr_cycle(input bit en, input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = en; wr_data = d;
    if (en && full_n) q.push_back(d);
    @(posedge wclk);
    #0.2 wr_en = 1'b0;
  endtask

  task automatic rd_cycle(input bit en);
    bit acc;
    logic [DW-1:0] e;
    @(negedge rclk);
    rd_en = en;
    acc = en && empty_n;
    @(posedge rclk);
    #0.2 rd_en = 1'b0;
    if (acc) begin
      e = (q.size() > 0) ? q.pop_front() : '0;
      chk(rd_data == e, "R2 order", int'(rd_data), int'(e));
      last_rd = e;
    end else begin
      chk(rd_data == last_rd, en ? "R3 read while empty" : "R2 hold",
          int'(rd_data), int'(last_rd));
    end
  endtask

  initial begin
    int lat;
    void'($urandom(32'd1234));
    #12;
    // R1 reset state
    chk(empty_n == 1'b0, "R1 empty", int'(empty_n), 0);
    chk(aempty_n == 1'b0, "R1 aempty", int'(aempty_n), 0);
    chk(full_n == 1'b1, "R1 full", int'(full_n), 1);
    chk(afull_n == 1'b1, "R1 afull", int'(afull_n), 1);
    chk(rd_data == '0, "R1 rdata", int'(rd_data), 0);
    #0.3 rst_n = 1'b1;
    settle_check();

    // R8 first-word latency into an empty FIFO
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 18'h2A5A5; q.push_back(18'h2A5A5);
    @(posedge wclk);
    #0.2 wr_en = 1'b0;
    lat = 0;
    while (lat < 10) begin
      @(posedge rclk); #0.3; lat++;
      if (empty_n) break;
    end
    chk(lat == 3, "R8 empty release edges", lat, 3);
    rd_cycle(1'b1);
    settle_check();
    // R3 read while empty leaves data alone
    rd_cycle(1'b1);
    rd_cycle(1'b1);
    settle_check();

    // fill with threshold checks at default offsets (R5, R6)
    for (int i = 0; i < DEPTH; i++) begin
      wr_cycle(1'b1, DW'($urandom));
      if (q.size() inside {7, 8, 9, 503, 504, 511, 512}) settle_check();
    end
    // R4 writes while full are dropped
    wr_cycle(1'b1, 18'h3FFFF);
    wr_cycle(1'b1, 18'h3FFFE);
    settle_check();

    // R8 full release latency
    @(negedge rclk);
    rd_en = 1'b1;
    @(posedge rclk);
    #0.2 rd_en = 1'b0;
    last_rd = q.pop_front();
    chk(rd_data == last_rd, "R2 order", int'(rd_data), int'(last_rd));
    lat = 0;
    while (lat < 10) begin
      @(posedge wclk); #0.3; lat++;
      if (full_n) break;
    end
    chk(lat == 3, "R8 full release edges", lat, 3);

    // drain to 25 words
    while (q.size() > 25) rd_cycle(1'b1);
    settle_check();
    // R7 offset change moves aempty_n
    aempty_ofs = 9'd30; n_cur = 30;
    settle_check();
    afull_ofs = 9'd490; m_cur = 490;
    settle_check();

    // random concurrent traffic
    aempty_ofs = 9'd20; n_cur = 20;
    afull_ofs = 9'd30;  m_cur = 30;
    fork
      for (int i = 0; i < 600; i++) wr_cycle(($urandom % 4) != 0, DW'($urandom));
      for (int i = 0; i < 600; i++) rd_cycle(($urandom % 3) != 0);
    join
    settle_check();
    fork
      for (int i = 0; i < 900; i++) wr_cycle(1'b1, DW'($urandom));
      for (int i = 0; i < 300; i++) rd_cycle(($urandom % 5) == 0);
    join
    settle_check();
    for (int i = 0; i < 1200 && q.size() > 0; i++) rd_cycle(($urandom % 4) != 0);
    settle_check();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule